// File: doc/BRIEF.md
# PLL Multiplier Reprogramming Sequencer

This block changes the feedback multiplier of a PLL without glitching the clock it feeds. A single start pulse, together with a new multiplier word, launches a fixed series of register accesses on a simple request/ready master port. The series runs in this order:

- switch the PLL off and cut its output;
- load the new multiplier and set the pre/post dividers to unity;
- switch the PLL back on;
- poll the lock flag at timed intervals;
- release the clock output only once lock is seen.

The block reports the outcome with a one-cycle success or failure pulse. A busy flag covers the whole run.

The PLL registers sit at fixed offsets from a base address: status at +0x0, control at +0x4, multiplier at +0x8 and divider at +0xC. In the control register, bit 0 powers the PLL down, bit 1 selects bypass, bit 2 is direct input, bit 3 is direct output and bit 4 enables the clock. Lock is bit 0 of the status register. The poll interval is derived from the clock frequency and the wait time in microseconds (1250 cycles with the defaults).

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bus_req_o are all low.
- R2: A start_i pulse while idle raises busy_o on the next cycle, and the first access is a read of the control register at base+0x4.
- R3: The first write goes to control at base+0x4. Its value is the value read with bit 0 set and bits 1 to 4 cleared; all other bits are kept.
- R4: The next write puts the latched multiplier word at base+0x8. The write after that puts 0x00302062 at base+0xC.
- R5: The next write goes to control at base+0x4 with bit 0 cleared, bits 1 to 4 still clear, and the other bits kept.
- R6: An access holds bus_req_o, bus_we_o, bus_addr_o and bus_wdata_o steady until a cycle with bus_ready_i high. The next access starts only after that cycle.
- R7: Each status read at base+0x0 is accepted no earlier than the wait interval (WAIT_CYC cycles) after the preceding access completed. Only bit 0 of the returned data counts as lock.
- R8: When a status read shows lock, control at base+0x4 is written with bit 4 set and bit 0 clear. After that write, done_o pulses and busy_o is low in the same cycle.
- R9: If MAX_POLLS status reads (default 4) all show no lock, err_o pulses, busy_o drops, and no write with bit 4 set is issued.
- R10: A start_i pulse while busy_o is high is ignored. The running sequence and its latched multiplier are unchanged, and no second sequence follows.
- R11: done_o and err_o last one cycle each and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mdiv_i | input | DATA_W | New multiplier register word |
| busy_o | output | 1 | High from an accepted start until the end of the sequence |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle lock-timeout pulse |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ready_i |
| bus_ready_i | input | 1 | Access acknowledge |

## Verification
The hardest cases to reach from the ports are lock arriving only on a late poll and lock never arriving. Both depend on how many status reads have already happened. The bench's register model counts status reads and reports lock only from a chosen read onward, or never. It also returns set upper bits in the status word, so that only bit 0 is taken as lock. Ready latency is varied per run, and the spacing between accepted accesses is compared against the wait interval plus that latency.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_CTRL,
    S_WR_OFF,
    S_WR_MDIV,
    S_WR_NP,
    S_WR_ON,
    S_WAIT,
    S_RD_STAT,
    S_WR_CEN
  } seq_state_e;

  // control register bit positions (decoded by the PLL)
  localparam int CTL_PD   = 0;
  localparam int CTL_BYP  = 1;
  localparam int CTL_DIN  = 2;
  localparam int CTL_DOUT = 3;
  localparam int CTL_CEN  = 4;
  localparam int STAT_LOCK = 0;

  // register offsets from the PLL base
  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_MDIV = 4'h8;
  localparam logic [3:0] OFS_NP   = 4'hC;

  // divider word giving unity pre and post division
  localparam logic [31:0] NP_UNITY = 32'h0030_2062;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int WAIT_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i && !load_i && (cnt_q == '0);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int MAX_POLLS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       xfer_i,
  input  logic       lock_i,
  input  logic       expire_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       tmr_load_o,
  output logic       tmr_run_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int PW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);
  localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

  seq_state_e    state_q, state_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          poll_en;
  logic          last_poll;
  logic          done_d, err_d;

  assign last_poll = (poll_q == LAST_POLL);
  assign accept_o  = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start_i)  state_d = S_RD_CTRL;
      S_RD_CTRL: if (xfer_i)   state_d = S_WR_OFF;
      S_WR_OFF:  if (xfer_i)   state_d = S_WR_MDIV;
      S_WR_MDIV: if (xfer_i)   state_d = S_WR_NP;
      S_WR_NP:   if (xfer_i)   state_d = S_WR_ON;
      S_WR_ON:   if (xfer_i)   state_d = S_WAIT;
      S_WAIT:    if (expire_i) state_d = S_RD_STAT;
      S_RD_STAT: begin
        if (xfer_i) begin
          if (lock_i)         state_d = S_WR_CEN;
          else if (last_poll) begin
            state_d = S_IDLE;
            err_d   = 1'b1;
          end else            state_d = S_WAIT;
        end
      end
      S_WR_CEN: begin
        if (xfer_i) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    poll_en = accept_o || ((state_q == S_RD_STAT) && xfer_i && !lock_i);
    poll_d  = accept_o ? '0 : poll_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      err_o   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       poll_q <= '0;
    else if (poll_en) poll_q <= poll_d;
  end

  assign tmr_load_o = (state_d == S_WAIT) && (state_q != S_WAIT);
  assign tmr_run_o  = (state_q == S_WAIT);
  assign busy_o     = (state_q != S_IDLE);
  assign state_o    = state_q;

endmodule

// File: rtl/pll_seq_dpath.sv
module pll_seq_dpath
  import pll_seq_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic              accept_i,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] mdiv_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [DATA_W-1:0] PD_M  = DATA_W'(1) << CTL_PD;
  localparam logic [DATA_W-1:0] CEN_M = DATA_W'(1) << CTL_CEN;
  localparam logic [DATA_W-1:0] OFF_CLR =
    (DATA_W'(1) << CTL_BYP) | (DATA_W'(1) << CTL_DIN) |
    (DATA_W'(1) << CTL_DOUT) | CEN_M;
  localparam logic [DATA_W-1:0] NP_W = DATA_W'(NP_UNITY);

  logic [DATA_W-1:0] mdiv_q;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdiv_q <= '0;
    else if (accept_i) mdiv_q <= mdiv_i;
  end

  always_comb begin
    ctrl_en = xfer_i && ((state_i == S_RD_CTRL) || (state_i == S_WR_ON));
    if (state_i == S_RD_CTRL) ctrl_d = (rdata_i | PD_M) & ~OFF_CLR;
    else                      ctrl_d = ctrl_q & ~PD_M;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b1;
    addr_o  = BASE_ADDR + ADDR_W'(OFS_CTRL);
    wdata_o = '0;
    unique case (state_i)
      S_RD_CTRL: we_o = 1'b0;
      S_WR_OFF:  wdata_o = ctrl_q;
      S_WR_MDIV: begin
        addr_o  = BASE_ADDR + ADDR_W'(OFS_MDIV);
        wdata_o = mdiv_q;
      end
      S_WR_NP: begin
        addr_o  = BASE_ADDR + ADDR_W'(OFS_NP);
        wdata_o = NP_W;
      end
      S_WR_ON:  wdata_o = ctrl_q & ~PD_M;
      S_RD_STAT: begin
        we_o   = 1'b0;
        addr_o = BASE_ADDR + ADDR_W'(OFS_STAT);
      end
      S_WR_CEN: wdata_o = ctrl_q | CEN_M;
      default: begin
        req_o = 1'b0;
        we_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  parameter int                CLK_HZ    = 125_000_000,
  parameter int                WAIT_US   = 10,
  parameter int                MAX_POLLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mdiv_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  localparam int RAW_CYC  = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int WAIT_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  seq_state_e state;
  logic       accept, xfer, expire, tmr_load, tmr_run;

  assign xfer = bus_req_o && bus_ready_i;

  pll_seq_fsm #(.MAX_POLLS(MAX_POLLS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .xfer_i     (xfer),
    .lock_i     (bus_rdata_i[STAT_LOCK]),
    .expire_i   (expire),
    .state_o    (state),
    .accept_o   (accept),
    .tmr_load_o (tmr_load),
    .tmr_run_o  (tmr_run),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  pll_seq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .run_i    (tmr_run),
    .expire_o (expire)
  );

  pll_seq_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .accept_i (accept),
    .xfer_i   (xfer),
    .mdiv_i   (mdiv_i),
    .rdata_i  (bus_rdata_i),
    .req_o    (bus_req_o),
    .we_o     (bus_we_o),
    .addr_o   (bus_addr_o),
    .wdata_o  (bus_wdata_o)
  );

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
  import pll_seq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  parameter int                WAIT_CYC  = 1250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ready_i
);
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_NP   = BASE_ADDR + ADDR_W'(OFS_NP);
  localparam int GW = $clog2(WAIT_CYC + 2);
  localparam logic [GW-1:0] GMAX = GW'(WAIT_CYC);

  logic [GW-1:0] gap_q;
  logic          ctl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= '0;
    else if (bus_req_o && bus_ready_i) gap_q <= '0;
    else if (gap_q != GMAX)            gap_q <= gap_q + 1'b1;
  end

  assign ctl_wr = bus_req_o && bus_we_o && (bus_addr_o == A_CTRL);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata_o[CTL_PD]) |-> (bus_wdata_o[CTL_CEN:CTL_BYP] == '0)); // R3
  AST_NP_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o && bus_addr_o == A_NP) |-> (bus_wdata_o == DATA_W'(NP_UNITY))); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o))); // R6
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> busy_o); // R6
  AST_POLL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_we_o && bus_addr_o == A_STAT) |-> (gap_q >= GMAX)); // R7
  AST_CEN_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata_o[CTL_CEN]) |-> !bus_wdata_o[CTL_PD]); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R11

endmodule

bind pll_reprog_seq pll_seq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_ADDR (BASE_ADDR),
  .WAIT_CYC  (WAIT_CYC)
) i_pll_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ready_i (bus_ready_i)
);

// File: tb/test_pll_reprog_seq.sv
`timescale 1ns/1ps
module test_pll_reprog_seq;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [7:0] BASE = 8'h40;
  localparam int WAIT_CYC = 1250; // 125 MHz * 10 us
  localparam logic [7:0] A_STAT = BASE + 8'h0;
  localparam logic [7:0] A_CTRL = BASE + 8'h4;
  localparam logic [7:0] A_MDIV = BASE + 8'h8;
  localparam logic [7:0] A_NP   = BASE + 8'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [DATA_W-1:0] mdiv_i = '0;
  logic busy_o, done_o, err_o, bus_req_o, bus_we_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;
  logic [DATA_W-1:0] bus_rdata_i = '0;
  logic bus_ready_i = 1'b0;

  always #4 clk = ~clk;

  pll_reprog_seq i_pll_reprog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mdiv_i(mdiv_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // register and lock model
  int lat = 0;
  int lock_after = 0;  // 0 = never locks
  int stat_reads = 0;
  int wcnt = 0;
  logic [31:0] ctrl_reg = '0;
  int log_n = 0;
  logic [7:0]  log_addr [32];
  logic        log_we   [32];
  logic [31:0] log_data [32];
  int          log_cyc  [32];

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ready_i = 1'b0;
      wcnt = 0;
    end else if (bus_ready_i) begin
      bus_ready_i = 1'b0;
      wcnt = 0;
    end else if (bus_req_o) begin
      if (wcnt >= lat) begin
        bus_ready_i = 1'b1;
        if (bus_addr_o == A_STAT) begin
          stat_reads++;
          bus_rdata_i = 32'hFFFF_FFF0 |
            ((lock_after != 0 && stat_reads >= lock_after) ? 32'h1 : 32'h0);
        end else begin
          bus_rdata_i = ctrl_reg;
        end
        if (bus_we_o && bus_addr_o == A_CTRL) ctrl_reg = bus_wdata_o;
        if (log_n < 32) begin
          log_addr[log_n] = bus_addr_o;
          log_we[log_n]   = bus_we_o;
          log_data[log_n] = bus_wdata_o;
          log_cyc[log_n]  = cyc;
        end
        log_n++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int n_done, n_err, done_w, err_w;
  bit overlap_seen, busy_at_end;

  task automatic run_seq(input logic [31:0] mdiv, input int l, input int lk,
                         input logic [31:0] cinit, input bit restart);
    int guard;
    lat = l; lock_after = lk; stat_reads = 0; ctrl_reg = cinit; log_n = 0;
    n_done = 0; n_err = 0; done_w = 0; err_w = 0; overlap_seen = 0; busy_at_end = 1;
    @(negedge clk);
    mdiv_i = mdiv; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mdiv_i = 32'hDEAD_BEEF;
    chk(busy_o === 1'b1, "R2 busy after start", {31'b0, busy_o}, 32'h1);
    guard = 0;
    while (!(done_o || err_o) && guard < 30000) begin
      guard++;
      if (restart && guard == 5) begin start_i = 1'b1; mdiv_i = ~mdiv; end
      else if (restart && guard == 6) start_i = 1'b0;
      @(negedge clk);
    end
    chk(guard < 30000, "R8 sequence finished", guard, 0);
    busy_at_end = busy_o;
    overlap_seen = done_o && err_o;
    // count pulse widths over the next cycles and confirm no restart
    for (int i = 0; i < 20; i++) begin
      if (done_o) done_w++;
      if (err_o) err_w++;
      @(negedge clk);
    end
  endtask

  task automatic verify_log(input logic [31:0] mdiv, input logic [31:0] cinit,
                            input int polls, input bit locked, input string tag);
    logic [31:0] off_v, on_v;
    int exp_n;
    off_v = (cinit | 32'h1) & ~32'h1E;
    on_v  = off_v & ~32'h1;
    exp_n = 5 + polls + (locked ? 1 : 0);
    chk(log_n == exp_n, {tag, " R10 access count"}, log_n, exp_n);
    if (log_n < exp_n) return;
    chk(log_addr[0] == A_CTRL && !log_we[0], {tag, " R2 first read ctrl"}, {24'b0, log_addr[0]}, {24'b0, A_CTRL});
    chk(log_addr[1] == A_CTRL && log_we[1] && log_data[1] == off_v, {tag, " R3 power-off write"}, log_data[1], off_v);
    chk(log_addr[2] == A_MDIV && log_we[2] && log_data[2] == mdiv, {tag, " R4 mdiv write"}, log_data[2], mdiv);
    chk(log_addr[3] == A_NP && log_we[3] && log_data[3] == 32'h0030_2062, {tag, " R4 np write"}, log_data[3], 32'h0030_2062);
    chk(log_addr[4] == A_CTRL && log_we[4] && log_data[4] == on_v, {tag, " R5 power-on write"}, log_data[4], on_v);
    for (int p = 0; p < polls; p++) begin
      chk(log_addr[5+p] == A_STAT && !log_we[5+p], {tag, " R7 status read"}, {24'b0, log_addr[5+p]}, {24'b0, A_STAT});
      chk(log_cyc[5+p] - log_cyc[4+p] == WAIT_CYC + 1 + lat, {tag, " R7 poll spacing"},
          log_cyc[5+p] - log_cyc[4+p], WAIT_CYC + 1 + lat);
    end
    for (int k = 1; k < 5; k++)
      chk(log_cyc[k] - log_cyc[k-1] == 2 + lat, {tag, " R6 access spacing"},
          log_cyc[k] - log_cyc[k-1], 2 + lat);
    if (locked) begin
      chk(log_addr[5+polls] == A_CTRL && log_we[5+polls] && log_data[5+polls] == (on_v | 32'h10),
          {tag, " R8 clock-enable write"}, log_data[5+polls], on_v | 32'h10);
      chk(n_done == 0 && done_w == 1 && err_w == 0, {tag, " R11 single done pulse"}, done_w, 1);
    end else begin
      chk(ctrl_reg[4] == 1'b0, {tag, " R9 clock-enable stays clear"}, ctrl_reg, on_v);
      chk(err_w == 1 && done_w == 0, {tag, " R9 single err pulse"}, err_w, 1);
    end
    chk(!busy_at_end && !overlap_seen, {tag, " R11 idle at end, no overlap"}, {31'b0, busy_at_end}, 0);
    chk(busy_o == 1'b0 && bus_req_o == 1'b0, {tag, " R10 stays idle"}, {31'b0, busy_o}, 0);
  endtask

  task automatic t_reset;
    chk(busy_o === 1'b0, "R1 busy reset", {31'b0, busy_o}, 0);
    chk(done_o === 1'b0 && err_o === 1'b0, "R1 pulses reset", {30'b0, done_o, err_o}, 0);
    chk(bus_req_o === 1'b0, "R1 req reset", {31'b0, bus_req_o}, 0);
  endtask

  task automatic t_lock_first;
    run_seq(32'h0001_2345, 0, 1, 32'h0000_001F, 0);
    verify_log(32'h0001_2345, 32'h0000_001F, 1, 1, "lock1");
  endtask

  task automatic t_lock_late;
    run_seq(32'h0A5C_3F01, 2, 3, 32'hA5A5_0006, 0);
    verify_log(32'h0A5C_3F01, 32'hA5A5_0006, 3, 1, "lock3");
  endtask

  task automatic t_lock_last;
    run_seq(32'h0000_7777, 1, 4, 32'h1234_5008, 0);
    verify_log(32'h0000_7777, 32'h1234_5008, 4, 1, "lock4");
  endtask

  task automatic t_no_lock;
    run_seq(32'h0003_0001, 1, 0, 32'h0000_0010, 0);
    verify_log(32'h0003_0001, 32'h0000_0010, 4, 0, "nolock");
  endtask

  task automatic t_start_busy;
    // R10: a second start with another word mid-run must be ignored
    run_seq(32'h0002_4680, 0, 2, 32'h0000_0000, 1);
    verify_log(32'h0002_4680, 32'h0000_0000, 2, 1, "restart R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_lock_first();
    t_lock_late();
    t_lock_last();
    t_no_lock();
    t_start_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule